// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models a small serial EEPROM target. It holds a 256 x 8 array in registers and talks to a host over three inputs: select, serial clock and serial data in. It drives one serial data output together with an output enable, and the output enable models the high-impedance state of a shared pin. All three inputs are sampled in the system clock domain through synchronizers. Serial clock edges are found by comparing successive synchronized samples.

A transaction opens with a start bit. A two-bit command code follows, then the address field, and for store commands a data byte. The block can read, with sequential continuation. It can store a byte, erase a byte, erase the whole array, fill the whole array with one byte, and turn the write enable on or off. A store or erase does not start on a clock edge. It starts a self-timed programming cycle on the falling edge of select, and the length of that cycle is a parameter. When the host raises select again, the data output shows busy or ready.

Top module: `tw_eeprom_target`

## Requirements
- R1: After reset the output enable is low, writing is disabled and every array byte reads 0xFF.
- R2: A start bit is the first serial clock rise at which select and data in are both high. Clocks with data in low before it, and any clocks while select is low, cause no state change.
- R3: The two bits after the start bit select the command: 10 reads, 01 stores, 11 erases one byte. Code 00 uses the next two bits: 11 enables writing, 00 disables it, 10 erases all and 01 fills all.
- R4: A read carries one don't-care bit and then an 8-bit address, MSB first. On the clock that takes in the last address bit, the output enable rises and the output is 0. Each later clock rise then presents the next data bit, MSB first.
- R5: While select stays high during a read, further clocks stream the following addresses, and 0xFF wraps to 0x00 with no extra zero bit.
- R6: A store carries the don't-care bit, the address and a data byte, 20 clocks in all. On the next falling edge of select, the byte is written to that address.
- R7: Erase sets the addressed byte to 0xFF. Erase-all sets every byte to 0xFF. Fill-all writes its data byte to every address.
- R8: Store, erase, erase-all and fill-all have effect only while writing is enabled. Disable turns writing off again. Reads work in either state.
- R9: Once a programming cycle has started, raising select drives the output enable high. The output is 0 for PROG_CYCLES system clocks and then 1.
- R10: The output enable drops on every falling edge of select and stays low while select is low.
- R11: A command cut short by select falling before all its bits have arrived is discarded: no array change and no busy status.
- R12: Once a non-read command has all its bits, further clocks and data are ignored until select falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Select, active high, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| sdo_o | output | 1 | Serial data out (read data or ready/busy) |
| sdo_oe_o | output | 1 | Output enable; low means high impedance |

## Verification
The assertions assume that the serial clock, select and data in change far more slowly than the system clock. Each serial clock level must last several system clocks so that every rise is seen exactly once after synchronization. They also assume that data in is stable around each serial clock rise. The stimulus holds each serial clock phase for four system clocks and changes data only in the low phase. It keeps select low for six system clocks between commands, so every falling edge of select is seen before the next start bit.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STORE,
        OP_ERASE,
        OP_ERASE_ALL,
        OP_FILL_ALL
    } prog_op_e;

    typedef struct packed {
        prog_op_e            op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } prog_cmd_t;

    typedef enum logic [1:0] {
        FE_IDLE,
        FE_SHIFT,
        FE_READ,
        FE_DONE
    } fe_state_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/tw_front.sv
module tw_front
    import tw_eeprom_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_s_i,
    input  logic              cs_fall_i,
    input  logic              sck_rise_i,
    input  logic              sdi_s_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              go_o,
    output prog_cmd_t         cmd_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int unsigned HDR_BITS = 2 + 1 + ADDR_W;
    localparam int unsigned TOT_BITS = HDR_BITS + DATA_W;
    localparam int unsigned CNT_W    = $clog2(TOT_BITS + 1);
    localparam int unsigned BIT_W    = $clog2(DATA_W);

    typedef struct packed {
        fe_state_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [HDR_BITS-2:0]   sreg;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     data;
        prog_op_e              op;
        logic [DATA_W-1:0]     sh;
        logic [BIT_W-1:0]      bitc;
        logic                  wen;
        logic                  stat;
        logic                  dout;
        logic                  oe;
    } fe_t;

    fe_t r_q, r_d;
    logic go;
    logic [HDR_BITS-1:0] sh_in;
    logic [DATA_W-1:0]   rd_byte;

    always_comb begin
        r_d     = r_q;
        go      = 1'b0;
        sh_in   = {r_q.sreg, sdi_s_i};
        rd_byte = (r_q.bitc == '0) ? rd_data_i : r_q.sh;
        if (!cs_s_i) begin
            go = cs_fall_i && (r_q.st == FE_DONE) && (r_q.op != OP_NONE)
                 && r_q.wen && !busy_i;
            r_d.st   = FE_IDLE;
            r_d.cnt  = '0;
            r_d.op   = OP_NONE;
            r_d.oe   = 1'b0;
            r_d.dout = 1'b0;
            if (go) r_d.stat = 1'b1;
        end else begin
            unique case (r_q.st)
                FE_IDLE: begin
                    r_d.oe   = r_q.stat;
                    r_d.dout = !busy_i;
                    if (sck_rise_i && sdi_s_i) begin
                        r_d.st   = FE_SHIFT;
                        r_d.cnt  = '0;
                        r_d.stat = 1'b0;
                        r_d.oe   = 1'b0;
                        r_d.dout = 1'b0;
                    end
                end
                FE_SHIFT: begin
                    if (sck_rise_i) begin
                        r_d.sreg = sh_in[HDR_BITS-2:0];
                        r_d.cnt  = r_q.cnt + 1'b1;
                        if (r_q.cnt == CNT_W'(HDR_BITS - 1)) begin
                            r_d.addr = sh_in[ADDR_W-1:0];
                            unique case (sh_in[HDR_BITS-1 -: 2])
                                2'b10: begin
                                    r_d.st   = FE_READ;
                                    r_d.oe   = 1'b1;
                                    r_d.dout = 1'b0;
                                    r_d.bitc = '0;
                                end
                                2'b01: r_d.op = OP_STORE;
                                2'b11: begin
                                    r_d.op = OP_ERASE;
                                    r_d.st = FE_DONE;
                                end
                                default: begin
                                    unique case (sh_in[HDR_BITS-3 -: 2])
                                        2'b10: begin
                                            r_d.op = OP_ERASE_ALL;
                                            r_d.st = FE_DONE;
                                        end
                                        2'b01: r_d.op = OP_FILL_ALL;
                                        2'b11: begin
                                            r_d.wen = 1'b1;
                                            r_d.st  = FE_DONE;
                                        end
                                        default: begin
                                            r_d.wen = 1'b0;
                                            r_d.st  = FE_DONE;
                                        end
                                    endcase
                                end
                            endcase
                        end else if (r_q.cnt == CNT_W'(TOT_BITS - 1)) begin
                            r_d.data = sh_in[DATA_W-1:0];
                            r_d.st   = FE_DONE;
                        end
                    end
                end
                FE_READ: begin
                    if (sck_rise_i) begin
                        r_d.dout = rd_byte[DATA_W-1];
                        r_d.sh   = rd_byte << 1;
                        if (r_q.bitc == BIT_W'(DATA_W - 1)) begin
                            r_d.bitc = '0;
                            r_d.addr = r_q.addr + 1'b1;
                        end else begin
                            r_d.bitc = r_q.bitc + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= FE_IDLE;
            r_q.op <= OP_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr_o = r_q.addr;
    assign go_o      = go;
    assign cmd_o     = '{op: r_q.op, addr: r_q.addr, data: r_q.data};
    assign sdo_o     = r_q.dout;
    assign sdo_oe_o  = r_q.oe;

    // R10: output released one cycle after select falls
    p_oe_off_after_cs_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_fall_i |=> !sdo_oe_o);

    // R8: the write-enable latch only moves on a serial clock rise
    p_wen_on_clock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(r_q.wen) |-> $past(sck_rise_i));

    // R3: bit counter never runs past the longest frame
    p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == FE_SHIFT) |-> (r_q.cnt < CNT_W'(TOT_BITS)));

    // R4: read data bits change only after a serial clock rise
    p_read_bit_on_clock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((r_q.st == FE_READ) && $past(r_q.st == FE_READ) && !$stable(sdo_o))
        |-> $past(sck_rise_i));

endmodule

// File: rtl/tw_prog.sv
module tw_prog
    import tw_eeprom_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 1000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  prog_cmd_t         cmd_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o
);

    localparam int unsigned CW   = $clog2(PROG_CYCLES + 1);
    localparam int unsigned LAST = PROG_CYCLES - 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        prog_cmd_t     cmd;
    } pg_t;

    pg_t  r_q, r_d;
    logic apply;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        r_d   = r_q;
        apply = 1'b0;
        if (r_q.busy) begin
            if (r_q.cnt == CW'(LAST)) begin
                r_d.busy = 1'b0;
                r_d.cnt  = '0;
                apply    = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else if (go_i) begin
            r_d.busy = 1'b1;
            r_d.cnt  = '0;
            r_d.cmd  = cmd_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q        <= '0;
            r_q.cmd.op <= OP_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (apply) begin
            unique case (r_q.cmd.op)
                OP_STORE:     mem_q[r_q.cmd.addr] <= r_q.cmd.data;
                OP_ERASE:     mem_q[r_q.cmd.addr] <= '1;
                OP_ERASE_ALL: for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
                OP_FILL_ALL:  for (int i = 0; i < DEPTH; i++) mem_q[i] <= r_q.cmd.data;
                default: ;
            endcase
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign busy_o    = r_q.busy;

    // R9: a cycle is only launched while idle
    p_go_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i |-> !r_q.busy);

    // R9: busy holds until the counter reaches its end
    p_busy_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.busy && (r_q.cnt != CW'(LAST))) |=> r_q.busy);

    // R9: counter stays within the cycle length
    p_cnt_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.busy |-> (r_q.cnt <= CW'(LAST)));

endmodule

// File: rtl/tw_eeprom_target.sv
module tw_eeprom_target
    import tw_eeprom_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);

    logic [2:0] pins_s;
    logic cs_s, sck_s, sdi_s;
    logic cs_p_q, sck_p_q;
    logic cs_fall, sck_rise;
    logic go, busy;
    prog_cmd_t cmd;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({cs_i, sck_i, sdi_i}),
        .sync_o  (pins_s)
    );

    assign {cs_s, sck_s, sdi_s} = pins_s;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_p_q  <= 1'b0;
            sck_p_q <= 1'b0;
        end else begin
            cs_p_q  <= cs_s;
            sck_p_q <= sck_s;
        end
    end

    assign cs_fall  = cs_p_q & ~cs_s;
    assign sck_rise = sck_s & ~sck_p_q;

    tw_front i_front (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cs_s_i     (cs_s),
        .cs_fall_i  (cs_fall),
        .sck_rise_i (sck_rise),
        .sdi_s_i    (sdi_s),
        .busy_i     (busy),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .go_o       (go),
        .cmd_o      (cmd),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o)
    );

    tw_prog #(.PROG_CYCLES(PROG_CYCLES)) i_prog (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .go_i      (go),
        .cmd_i     (cmd),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .busy_o    (busy)
    );

    // R10: the output is never enabled while synchronized select is low
    p_no_drive_cs_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_s && !cs_p_q) |-> !sdo_oe_o);

endmodule

// File: tb/test_tw_eeprom_target.sv
module test_tw_eeprom_target;

    localparam int PROG = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] mem_m [256];
    bit         wen_m = 0;

    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    tw_eeprom_target #(.PROG_CYCLES(PROG)) i_tw_eeprom_target (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .cs_i     (cs),
        .sck_i    (sck),
        .sdi_i    (sdi),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse();
        sck = 1'b1; tick(4);
        sck = 1'b0; tick(4);
    endtask

    task automatic send_bits(logic [19:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            pulse();
        end
        sdi = 1'b0;
    endtask

    task automatic cs_up();
        cs = 1'b1; tick(4);
    endtask

    task automatic cs_down();
        cs = 1'b0; sdi = 1'b0; tick(6);
    endtask

    // status after a launched cycle: busy, then ready (R9)
    task automatic wait_prog(string req);
        cs = 1'b1; tick(5);
        chk({req, " R9 busy"}, {sdo_oe, sdo}, 2'b10);
        for (int i = 0; i < 2 * PROG && sdo !== 1'b1; i++) tick(1);
        chk({req, " R9 ready"}, {sdo_oe, sdo}, 2'b11);
        cs_down();
    endtask

    task automatic no_status(string req);
        cs = 1'b1; tick(5);
        chk({req, " no status"}, sdo_oe, 0);
        cs_down();
    endtask

    task automatic rd(logic [7:0] a, int n, string req);
        logic [7:0] b;
        cs_up();
        send_bits({8'h0, 1'b1, 2'b10, 1'b0, a}, 12);
        chk({req, " R4 dummy"}, {sdo_oe, sdo}, 2'b10);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(mem_m[8'(a + k)]);
            tag_q.push_back(req);
            for (int j = 0; j < 8; j++) begin
                pulse();
                b = {b[6:0], sdo};
            end
            act_q.push_back(b);
        end
        cs_down();
        chk("R10 released", sdo_oe, 0);
    endtask

    task automatic store(logic [7:0] a, logic [7:0] d);
        cs_up();
        send_bits({1'b1, 2'b01, 1'b0, a, d}, 20);
        if (wen_m) mem_m[a] = d;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                chk({tag_q.pop_front(), " read byte"}, act_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
        tick(5);
        chk("R1 oe at reset", sdo_oe, 0);
        rst_n = 1'b1;
        tick(3);

        // R1: array reads all ones
        rd(8'h05, 2, "R1");

        // R8: store while disabled has no effect
        store(8'h10, 8'h5A);
        cs_down();
        no_status("R8 disabled");
        rd(8'h10, 1, "R8 disabled");

        // R2: clocks while deselected and zeros before start are ignored
        sdi = 1'b1;
        for (int i = 0; i < 3; i++) pulse();
        cs_up();
        send_bits(20'h0, 5);
        send_bits({8'h0, 12'b1_00_11_0000000}, 12);
        wen_m = 1;
        cs_down();

        // R3 R6: store after enable
        store(8'h10, 8'h5A);
        cs_down();
        wait_prog("R6");
        rd(8'h10, 1, "R6 R3");

        // R12: extra clocks after complete store are ignored
        store(8'h20, 8'h81);
        sdi = 1'b1;
        for (int i = 0; i < 6; i++) pulse();
        cs_down();
        wait_prog("R12");
        rd(8'h20, 1, "R12");

        // R5: sequential read wraps
        store(8'hFF, 8'hC3);
        cs_down();
        wait_prog("R5");
        rd(8'hFF, 3, "R5");

        // R11: truncated store discarded
        cs_up();
        send_bits({1'b1, 2'b01, 1'b0, 8'h10, 8'h00} >> 5, 15);
        cs_down();
        no_status("R11");
        rd(8'h10, 1, "R11");

        // R7: erase one byte
        cs_up();
        send_bits({8'h0, 1'b1, 2'b11, 1'b0, 8'h10}, 12);
        mem_m[8'h10] = 8'hFF;
        cs_down();
        wait_prog("R7 erase");
        rd(8'h10, 1, "R7 erase");

        // R7: fill all
        cs_up();
        send_bits({1'b1, 2'b00, 2'b01, 7'h0, 8'h3C}, 20);
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h3C;
        cs_down();
        wait_prog("R7 fill");
        rd(8'h00, 2, "R7 fill");
        rd(8'h80, 1, "R7 fill");

        // R7: erase all
        cs_up();
        send_bits({8'h0, 1'b1, 2'b00, 2'b10, 7'h0}, 12);
        for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
        cs_down();
        wait_prog("R7 erase all");
        rd(8'h7F, 2, "R7 erase all");

        // R8: disable, then store ignored, read still works
        cs_up();
        send_bits({8'h0, 1'b1, 2'b00, 2'b00, 7'h0}, 12);
        wen_m = 0;
        cs_down();
        store(8'h44, 8'h00);
        cs_down();
        no_status("R8 after disable");
        rd(8'h44, 1, "R8 after disable");

        // R10: oe drops when select falls mid-read
        cs_up();
        send_bits({8'h0, 1'b1, 2'b10, 1'b0, 8'h01}, 12);
        pulse();
        chk("R10 driving", sdo_oe, 1);
        cs = 1'b0; tick(5);
        chk("R10 cs fall", sdo_oe, 0);
        tick(3);

        tick(20);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule